// File: doc/BRIEF.md
# Receive Chunk Footer Parser and Frame Reassembler

This block sits on the host side of a serial link that carries Ethernet receive traffic in fixed chunks. Each chunk arrives as a byte stream: a payload of `PAY_BYTES` bytes (64 by default) and then a 32-bit trailer sent most significant byte first. The trailer says whether the payload holds frame data, where a frame starts and ends inside it, whether the finished frame should be discarded, and whether a timestamp was placed in front of the frame. Because all of this is known only once the trailer is in, the block holds the whole payload in a local buffer. It checks the trailer's odd parity and then walks the buffered bytes in index order. From them it rebuilds frames on an output byte stream that carries start, end, drop and abort markers.

A state machine sequences the work. In `S_FILL` the block accepts bytes (`in_ready` high). After the last trailer byte comes `S_CHECK`, which takes one cycle to judge parity and data-valid. `S_DRAIN` then visits each payload index once. The transitions are: FILL→CHECK when the final trailer byte is accepted; CHECK→DRAIN when parity is good and data-valid is set; CHECK→FILL otherwise; DRAIN→FILL after the last payload index. Link status from the latest good trailer is held on dedicated outputs. A configuration pair selects whether a 32-bit or 64-bit prepended timestamp is pulled out of the frame and presented on a sideband.

Top module: `rxf_reassembler`

## Requirements
- R1: A chunk is 68 accepted bytes (`in_valid` and `in_ready` both high): indices 0..63 are payload and indices 64..67 are the trailer, bits 31..24 first. `in_ready` goes low after the 68th byte and returns high once the drain is complete.
- R2: The trailer must have an odd number of ones across all 32 bits. A trailer that fails this check raises `hdr_err` for one cycle, produces no output bytes and leaves every status output unchanged.
- R3: When trailer bit 21 (data valid) is 0, the payload produces no output. A frame that is already open stays open across such a chunk.
- R4: Trailer bit 20 marks a frame start at payload byte 4×(bits 19..16). The first byte emitted for that frame carries `out_sof`.
- R5: Trailer bit 14 marks a frame end at the payload byte given by bits 13..8, which is emitted with `out_eof`. Frames may span any number of chunks, and bytes leave in payload index order.
- R6: Trailer bit 15 set with an end present makes the end byte carry `out_drop`.
- R7: If a chunk carries both an end and a start that lies after the end, the open frame ends first and the new frame starts later in the same chunk.
- R8: A start that arrives while a frame is open raises `out_abort`, which terminates the open frame. The pulse may share its cycle with the new frame's first byte.
- R9: After a good trailer, `st_rca` = bits 28..24, `st_txc` = bits 5..1, `st_exst` = bit 31, `st_hdrb` = bit 30 and `st_sync` = bit 29.
- R10: With `cfg_ts_strip`=1, `cfg_ts_wide`=0 and trailer bit 7 set on a start, the first 4 frame bytes are removed. They appear big-endian in `ts_value[31:0]` with the upper half zero, together with a one-cycle `ts_valid`. `ts_perr` is 1 when those 32 bits plus trailer bit 6 hold an even number of ones.
- R11: With `cfg_ts_wide`=1, the first 8 frame bytes are removed into `ts_value[63:0]`, with parity judged over 64 bits and bit 6. The timestamp may end at the last payload byte while the frame continues in the next chunk.
- R12: With `cfg_ts_strip`=0, timestamp bytes pass through as ordinary frame bytes.
- R13: After reset, all output strobes and status outputs are 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_ts_strip | input | 1 | Remove a flagged prepended timestamp |
| cfg_ts_wide | input | 1 | Timestamp is 64-bit (1) or 32-bit (0) |
| in_valid | input | 1 | Chunk byte present |
| in_byte | input | 8 | Chunk byte |
| in_ready | output | 1 | Block accepts chunk bytes |
| out_valid | output | 1 | Frame byte present |
| out_byte | output | 8 | Frame byte |
| out_sof | output | 1 | First byte of frame |
| out_eof | output | 1 | Last byte of frame |
| out_drop | output | 1 | Frame marked for discard (with eof) |
| out_abort | output | 1 | Open frame terminated with error |
| ts_valid | output | 1 | Timestamp captured |
| ts_value | output | 64 | Captured timestamp |
| ts_perr | output | 1 | Timestamp parity failure |
| hdr_err | output | 1 | Trailer parity failure pulse |
| st_rca | output | 5 | Receive chunks still pending |
| st_txc | output | 5 | Transmit credits |
| st_exst | output | 1 | Extended status flag |
| st_hdrb | output | 1 | Peer saw a bad header |
| st_sync | output | 1 | Configuration sync flag |

## Verification
Single-chunk frames are swept over every start word offset, each with both a minimal end and an end at the final payload byte. This separates wrong offset scaling from off-by-one end handling, and the drop flag is alternated on the same sweep. Multi-chunk frames, with a data-invalid chunk placed in the middle, separate state kept between chunks from state that is reset per chunk. Chunks with an end before a start, and chunks with a start inside an open frame, tell the two boundary orderings apart. Timestamp frames run narrow, wide across a chunk edge and pass-through, with good and bad parity. A 32-step sweep of the status fields, plus a corrupted trailer, shows that status is taken only from trailers that pass the parity check.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    localparam int FOOT_BYTES = 4;

    // Trailer layout; bit positions are decoded by the peer, so they are fixed.
    typedef struct packed {
        logic       exst;   // 31
        logic       hdrb;   // 30
        logic       sync;   // 29
        logic [4:0] rca;    // 28..24
        logic [1:0] vs;     // 23..22
        logic       dv;     // 21
        logic       sv;     // 20
        logic [3:0] swo;    // 19..16
        logic       fd;     // 15
        logic       ev;     // 14
        logic [5:0] ebo;    // 13..8
        logic       rtsa;   // 7
        logic       rtsp;   // 6
        logic [4:0] txc;    // 5..1
        logic       par;    // 0
    } trailer_t;

    typedef enum logic [1:0] {
        S_FILL  = 2'd0,
        S_CHECK = 2'd1,
        S_DRAIN = 2'd2
    } rx_state_t;
endpackage

// File: rtl/rxf_chunk_buf.sv
module rxf_chunk_buf
    import rxf_pkg::*;
#(
    parameter int PAY_BYTES = 64
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [7:0]                   wr_byte,
    input  logic [$clog2(PAY_BYTES)-1:0] rd_idx,
    output logic [7:0]                   rd_byte,
    output trailer_t                     trailer,
    output logic                         chunk_done
);
    localparam int TOTAL = PAY_BYTES + FOOT_BYTES;
    localparam int CNT_W = $clog2(TOTAL);
    localparam int IDX_W = $clog2(PAY_BYTES);

    logic [CNT_W-1:0] cnt;
    logic [7:0]       mem [PAY_BYTES];
    logic [31:0]      foot_q;
    logic             in_pay;

    assign in_pay     = cnt < CNT_W'(PAY_BYTES);
    assign chunk_done = wr_en && (cnt == CNT_W'(TOTAL - 1));
    assign rd_byte    = mem[rd_idx];
    assign trailer    = trailer_t'(foot_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            foot_q <= '0;
        end else if (wr_en) begin
            cnt <= chunk_done ? '0 : cnt + 1'b1;
            if (!in_pay) foot_q <= {foot_q[23:0], wr_byte};
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en && in_pay) mem[cnt[IDX_W-1:0]] <= wr_byte;
    end

    // R1: byte counter never leaves the chunk length
    p_cnt_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CNT_W'(TOTAL));
endmodule

// File: rtl/rxf_footer_chk.sv
module rxf_footer_chk
    import rxf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       check,
    input  trailer_t   trailer,
    output logic       par_ok,
    output logic       hdr_err,
    output logic [4:0] st_rca,
    output logic [4:0] st_txc,
    output logic       st_exst,
    output logic       st_hdrb,
    output logic       st_sync
);
    assign par_ok = ^trailer;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hdr_err <= 1'b0;
            st_rca  <= '0;
            st_txc  <= '0;
            st_exst <= 1'b0;
            st_hdrb <= 1'b0;
            st_sync <= 1'b0;
        end else begin
            hdr_err <= check && !par_ok;
            if (check && par_ok) begin
                st_rca  <= trailer.rca;
                st_txc  <= trailer.txc;
                st_exst <= trailer.exst;
                st_hdrb <= trailer.hdrb;
                st_sync <= trailer.sync;
            end
        end
    end

    // R2: a failing trailer raises the error and leaves status alone
    p_bad_keeps_status_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (check && !par_ok) |=> (hdr_err && $stable(st_rca) && $stable(st_txc)
                                && $stable(st_exst) && $stable(st_hdrb) && $stable(st_sync)));
endmodule

// File: rtl/rxf_ts_capture.sv
module rxf_ts_capture (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        upd,
    input  logic [3:0]  cnt_in,
    input  logic        take,
    input  logic [7:0]  byte_in,
    input  logic        clr,
    input  logic        arm,
    input  logic        arm_wide,
    input  logic        arm_par,
    output logic [3:0]  left,
    output logic        ts_valid,
    output logic [63:0] ts_value,
    output logic        ts_perr
);
    logic [63:0] shift_q, shift_n;
    logic        wide_q, par_q, finish;
    logic [63:0] sel;

    assign shift_n = {shift_q[55:0], byte_in};
    assign finish  = upd && take && (cnt_in == 4'd1);
    assign sel     = wide_q ? shift_n : {32'd0, shift_n[31:0]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left     <= '0;
            shift_q  <= '0;
            wide_q   <= 1'b0;
            par_q    <= 1'b0;
            ts_valid <= 1'b0;
            ts_value <= '0;
            ts_perr  <= 1'b0;
        end else begin
            ts_valid <= finish;
            if (arm) begin
                wide_q <= arm_wide;
                par_q  <= arm_par;
            end
            if (upd) left <= clr ? 4'd0 : (take ? cnt_in - 4'd1 : cnt_in);
            if (upd && take) shift_q <= shift_n;
            if (finish) begin
                ts_value <= sel;
                ts_perr  <= ~(^sel ^ par_q);
            end
        end
    end

    // R10: capture strobe is a single-cycle pulse
    p_ts_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ts_valid |=> !ts_valid);
endmodule

// File: rtl/rxf_reassembler.sv
module rxf_reassembler
    import rxf_pkg::*;
#(
    parameter int PAY_BYTES = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_ts_strip,
    input  logic        cfg_ts_wide,
    input  logic        in_valid,
    input  logic [7:0]  in_byte,
    output logic        in_ready,
    output logic        out_valid,
    output logic [7:0]  out_byte,
    output logic        out_sof,
    output logic        out_eof,
    output logic        out_drop,
    output logic        out_abort,
    output logic        ts_valid,
    output logic [63:0] ts_value,
    output logic        ts_perr,
    output logic        hdr_err,
    output logic [4:0]  st_rca,
    output logic [4:0]  st_txc,
    output logic        st_exst,
    output logic        st_hdrb,
    output logic        st_sync
);
    localparam int IDX_W = $clog2(PAY_BYTES);
    localparam int POS_W = 8;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(PAY_BYTES - 1);

    rx_state_t         state, state_n;
    trailer_t          trailer;
    logic              chunk_done, par_ok, in_drain, check;
    logic [IDX_W-1:0]  idx;
    logic [7:0]        rd_byte;
    logic              open_q, sofp_q;
    logic [3:0]        ts_left, left_a;
    logic [POS_W-1:0]  idx_pos, start_pos, end_pos;
    logic              starting, ending, open_a, sof_a, take, emit, abort_n;

    assign in_ready = (state == S_FILL);
    assign in_drain = (state == S_DRAIN);
    assign check    = (state == S_CHECK);

    rxf_chunk_buf #(.PAY_BYTES(PAY_BYTES)) u_buf (
        .clk(clk), .rst_n(rst_n),
        .wr_en(in_valid && in_ready), .wr_byte(in_byte),
        .rd_idx(idx), .rd_byte(rd_byte),
        .trailer(trailer), .chunk_done(chunk_done)
    );

    rxf_footer_chk u_chk (
        .clk(clk), .rst_n(rst_n), .check(check), .trailer(trailer),
        .par_ok(par_ok), .hdr_err(hdr_err),
        .st_rca(st_rca), .st_txc(st_txc),
        .st_exst(st_exst), .st_hdrb(st_hdrb), .st_sync(st_sync)
    );

    // Per-index walk decisions
    always_comb begin
        idx_pos   = POS_W'(idx);
        start_pos = POS_W'({trailer.swo, 2'b00});
        end_pos   = POS_W'(trailer.ebo);
        starting  = in_drain && trailer.sv && (idx_pos == start_pos);
        ending    = in_drain && trailer.ev && (idx_pos == end_pos);
        open_a    = starting || open_q;
        sof_a     = starting || sofp_q;
        if (starting)
            left_a = (trailer.rtsa && cfg_ts_strip) ? (cfg_ts_wide ? 4'd8 : 4'd4) : 4'd0;
        else
            left_a = ts_left;
        take    = in_drain && open_a && (left_a != 4'd0);
        emit    = in_drain && open_a && (left_a == 4'd0);
        abort_n = (starting && open_q) || (ending && take);
    end

    rxf_ts_capture u_ts (
        .clk(clk), .rst_n(rst_n),
        .upd(in_drain), .cnt_in(left_a), .take(take), .byte_in(rd_byte),
        .clr(ending), .arm(starting), .arm_wide(cfg_ts_wide), .arm_par(trailer.rtsp),
        .left(ts_left), .ts_valid(ts_valid), .ts_value(ts_value), .ts_perr(ts_perr)
    );

    // Next state
    always_comb begin
        state_n = state;
        unique case (state)
            S_FILL:  if (chunk_done) state_n = S_CHECK;
            S_CHECK: state_n = (par_ok && trailer.dv) ? S_DRAIN : S_FILL;
            S_DRAIN: if (idx == LAST) state_n = S_FILL;
            default: state_n = S_FILL;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_FILL;
        else        state <= state_n;
    end

    // Walk context carried between indices and chunks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx    <= '0;
            open_q <= 1'b0;
            sofp_q <= 1'b0;
        end else begin
            idx <= (in_drain && idx != LAST) ? idx + 1'b1 : '0;
            if (in_drain) begin
                open_q <= open_a && !ending;
                sofp_q <= sof_a && !emit && !ending;
            end
        end
    end

    // Outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_byte  <= '0;
            out_sof   <= 1'b0;
            out_eof   <= 1'b0;
            out_drop  <= 1'b0;
            out_abort <= 1'b0;
        end else begin
            out_valid <= emit;
            out_byte  <= emit ? rd_byte : 8'd0;
            out_sof   <= emit && sof_a;
            out_eof   <= emit && ending;
            out_drop  <= emit && ending && trailer.fd;
            out_abort <= abort_n;
        end
    end

    // R6: discard marker only on a frame's last byte
    p_drop_with_eof_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_drop |-> (out_eof && out_valid));
    // R3: a data-invalid chunk skips the drain
    p_dv0_skips_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (check && !trailer.dv) |=> (state == S_FILL));
    // R5: bytes only leave the cycle after a drain step
    p_out_after_drain_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($past(state) == S_DRAIN));
    // R1: no bytes accepted outside the fill phase
    p_fill_closed_r1: assert property (@(posedge clk) disable iff (!rst_n)
        chunk_done |=> !in_ready);
endmodule

// File: tb/test_rxf_reassembler.sv
`timescale 1ns/1ps
module test_rxf_reassembler;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_ts_strip = 1'b0, cfg_ts_wide = 1'b0;
    logic in_valid = 1'b0;
    logic [7:0] in_byte = 8'd0;
    logic in_ready, out_valid, out_sof, out_eof, out_drop, out_abort;
    logic [7:0] out_byte;
    logic ts_valid, ts_perr, hdr_err, st_exst, st_hdrb, st_sync;
    logic [63:0] ts_value;
    logic [4:0] st_rca, st_txc;

    always #2 clk = ~clk;

    rxf_reassembler i_rxf_reassembler (
        .clk(clk), .rst_n(rst_n), .cfg_ts_strip(cfg_ts_strip), .cfg_ts_wide(cfg_ts_wide),
        .in_valid(in_valid), .in_byte(in_byte), .in_ready(in_ready),
        .out_valid(out_valid), .out_byte(out_byte), .out_sof(out_sof), .out_eof(out_eof),
        .out_drop(out_drop), .out_abort(out_abort),
        .ts_valid(ts_valid), .ts_value(ts_value), .ts_perr(ts_perr), .hdr_err(hdr_err),
        .st_rca(st_rca), .st_txc(st_txc), .st_exst(st_exst), .st_hdrb(st_hdrb), .st_sync(st_sync)
    );

    int checks = 0, fails = 0, chunk_no = 0, perr_cnt = 0, ts_cnt = 0;
    logic [63:0] last_ts;
    logic last_tsperr;
    logic [12:0] got[$], exp_q[$];
    bit m_open = 0, m_sofp = 0;
    int m_left = 0;
    bit done = 0;

    // event: {abort, valid, sof, eof, drop, byte}
    always @(negedge clk) if (rst_n) begin
        if (out_valid || out_abort)
            got.push_back({out_abort, out_valid, out_sof, out_eof, out_drop, out_byte});
        if (hdr_err) perr_cnt++;
        if (ts_valid) begin ts_cnt++; last_ts = ts_value; last_tsperr = ts_perr; end
    end

    function automatic logic [7:0] pb(input int c, input int k);
        return 8'(c * 37 + k * 5 + 1);
    endfunction

    function automatic logic [31:0] mkf(input logic dv, sv, input logic [3:0] swo,
            input logic ev, input logic [5:0] ebo, input logic fd, rtsa, rtsp,
            input logic [4:0] rca, txc, input logic exst, hdrb, sync);
        logic [31:0] f;
        f = {exst, hdrb, sync, rca, 2'b00, dv, sv, swo, fd, ev, ebo, rtsa, rtsp, txc, 1'b0};
        f[0] = ~^f[31:1];
        return f;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // Expected events derived from the requirement text
    task automatic model_chunk(input logic [31:0] f, input int c);
        if ((^f) !== 1'b1 || !f[21]) return;
        for (int i = 0; i < 64; i++) begin
            bit st, en, ab;
            st = f[20] && (i == int'(f[19:16]) * 4);
            en = f[14] && (i == int'(f[13:8]));
            ab = 0;
            if (st) begin
                ab = m_open; m_open = 1; m_sofp = 1;
                m_left = (f[7] && cfg_ts_strip) ? (cfg_ts_wide ? 8 : 4) : 0;
            end
            if (m_open) begin
                if (m_left > 0) begin
                    m_left--;
                    if (en) begin ab = 1; m_open = 0; m_left = 0; end
                    if (ab) exp_q.push_back({1'b1, 12'd0});
                end else begin
                    exp_q.push_back({ab, 1'b1, m_sofp, en, en & f[15], pb(c, i)});
                    m_sofp = 0;
                    if (en) m_open = 0;
                end
            end
        end
    endtask

    task automatic send_chunk(input logic [31:0] f);
        model_chunk(f, chunk_no);
        for (int k = 0; k < 68; k++) begin
            @(negedge clk);
            while (!in_ready) @(negedge clk);
            in_valid = 1'b1;
            in_byte  = (k < 64) ? pb(chunk_no, k) : f[31 - 8 * (k - 64) -: 8];
        end
        @(negedge clk);
        in_valid = 1'b0;
        chunk_no++;
        while (!in_ready) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic cmp_events(input string tag);
        chk({tag, " event count"}, 64'(got.size()), 64'(exp_q.size()));
        if (got.size() == exp_q.size())
            foreach (got[i]) chk({tag, " event"}, 64'(got[i]), 64'(exp_q[i]));
        got.delete(); exp_q.delete();
    endtask

    function automatic bit has_abort();
        foreach (got[i]) if (got[i][12]) return 1;
        return 0;
    endfunction

    initial begin
        #(4 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [63:0] tsx;
        logic [4:0] s_rca, s_txc;
        int p0;
        repeat (4) @(negedge clk);
        // R13 reset state
        chk("R13 in_ready", 64'(in_ready), 64'd1);
        chk("R13 strobes", 64'({out_valid, out_abort, ts_valid, hdr_err}), 64'd0);
        chk("R13 status", 64'({st_rca, st_txc, st_exst, st_hdrb, st_sync}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4 R5 R6 R1: single-chunk frames over every start offset
        for (int s = 0; s < 16; s++) begin
            send_chunk(mkf(1, 1, 4'(s), 1, 6'(s * 4 + (s % 3)), s[0], 0, 0, 0, 0, 0, 0, 0));
            cmp_events("R4 R5 R6 short");
            send_chunk(mkf(1, 1, 4'(s), 1, 6'd63, ~s[0], 0, 0, 0, 0, 0, 0, 0));
            cmp_events("R4 R5 R6 to-last");
        end

        // R5 R3: frame across chunks with a data-invalid chunk inside
        send_chunk(mkf(1, 1, 4'd3, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0));
        send_chunk(mkf(0, 1, 4'd0, 1, 6'd2, 0, 0, 0, 0, 0, 0, 0, 0));
        chk("R3 dv0 no output", 64'(got.size()), 64'(exp_q.size()));
        send_chunk(mkf(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0));
        send_chunk(mkf(1, 0, 0, 1, 6'd10, 0, 0, 0, 0, 0, 0, 0, 0));
        cmp_events("R5 R3 multi-chunk");

        // R7: end before start in one chunk
        send_chunk(mkf(1, 1, 4'd2, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0));
        send_chunk(mkf(1, 1, 4'd5, 1, 6'd7, 1, 0, 0, 0, 0, 0, 0, 0));
        send_chunk(mkf(1, 0, 0, 1, 6'd3, 0, 0, 0, 0, 0, 0, 0, 0));
        chk("R7 no abort", 64'(has_abort()), 64'd0);
        cmp_events("R7 end-then-start");

        // R8: start inside an open frame
        send_chunk(mkf(1, 1, 4'd1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0));
        send_chunk(mkf(1, 1, 4'd4, 1, 6'd40, 0, 0, 0, 0, 0, 0, 0, 0));
        chk("R8 abort seen", 64'(has_abort()), 64'd1);
        cmp_events("R8 restart");

        // R2: corrupted trailer
        send_chunk(mkf(1, 0, 0, 0, 0, 0, 0, 0, 5'd9, 5'd7, 1, 0, 1));
        s_rca = st_rca; s_txc = st_txc;
        p0 = perr_cnt;
        send_chunk(mkf(1, 1, 4'd0, 1, 6'd20, 0, 0, 0, 5'd3, 5'd4, 0, 1, 0) ^ 32'h1);
        chk("R2 hdr_err pulse", 64'(perr_cnt - p0), 64'd1);
        chk("R2 no output", 64'(got.size()), 64'd0);
        chk("R2 status kept", 64'({st_rca, st_txc, st_exst, st_hdrb, st_sync}),
            64'({s_rca, s_txc, 3'b101}));
        cmp_events("R2 bad trailer");

        // R10: 32-bit timestamp removed
        cfg_ts_strip = 1; cfg_ts_wide = 0;
        tsx = {32'd0, pb(chunk_no, 8), pb(chunk_no, 9), pb(chunk_no, 10), pb(chunk_no, 11)};
        p0 = ts_cnt;
        send_chunk(mkf(1, 1, 4'd2, 1, 6'd30, 0, 1, ~^tsx, 0, 0, 0, 0, 0));
        chk("R10 ts strobe", 64'(ts_cnt - p0), 64'd1);
        chk("R10 ts value", last_ts, tsx);
        chk("R10 ts parity ok", 64'(last_tsperr), 64'd0);
        cmp_events("R10 strip32");

        // R11: 64-bit timestamp ending at the chunk edge, bad parity
        cfg_ts_wide = 1;
        tsx = 0;
        for (int k = 56; k < 64; k++) tsx = {tsx[55:0], pb(chunk_no, k)};
        p0 = ts_cnt;
        send_chunk(mkf(1, 1, 4'd14, 0, 0, 0, 1, ^tsx, 0, 0, 0, 0, 0));
        chk("R11 ts strobe", 64'(ts_cnt - p0), 64'd1);
        chk("R11 ts value", last_ts, tsx);
        chk("R11 ts parity bad", 64'(last_tsperr), 64'd1);
        chk("R11 no bytes yet", 64'(got.size()), 64'd0);
        send_chunk(mkf(1, 0, 0, 1, 6'd5, 0, 0, 0, 0, 0, 0, 0, 0));
        cmp_events("R11 strip64");

        // R12: strip disabled passes timestamp bytes
        cfg_ts_strip = 0;
        p0 = ts_cnt;
        send_chunk(mkf(1, 1, 4'd1, 1, 6'd25, 0, 1, 1, 0, 0, 0, 0, 0));
        chk("R12 no ts strobe", 64'(ts_cnt - p0), 64'd0);
        cmp_events("R12 passthrough");

        // R9: status sweep through data-invalid chunks
        for (int r = 0; r < 32; r++) begin
            send_chunk(mkf(0, 0, 0, 0, 0, 0, 0, 0, 5'(r), 5'(31 - r), r[0], r[1], r[2]));
            chk("R9 status", 64'({st_rca, st_txc, st_exst, st_hdrb, st_sync}),
                64'({5'(r), 5'(31 - r), r[0], r[1], r[2]}));
        end
        chk("R9 R3 quiet", 64'(got.size()), 64'd0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule